// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

A hardwired control sequencer for a 16-bit single-accumulator processor. Each 16-bit word fetched from an internal 4096 x 16 word store is read as a mode bit (bit 15), a 3-bit operation code (bits 14..12) and a 12-bit address (bits 11..0). The sequencer steps through fetch, decode, an optional pointer-follow step and one to three execute steps. It runs seven memory-reference operations, each in a direct and an indirect form. Words whose operation code is 7 go to a small register-and-I/O unit. That unit changes the accumulator and the carry flag E, may skip the next word, and raises the stop request.

Software fills the store through a preload port while reset is held. Reset is then released and the machine runs from address 0 until a halt word executes. The program counter, accumulator and instruction register can be read at the ports at all times.

Top module: `acc_seq_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_view`, `ac_view` and `ir_view` read 0 and `halted` reads 0.
- R2: Each fetch loads the word at the PC into the instruction register and adds one to the PC. Outside the fetch step the instruction register does not change.
- R3: With the mode bit at 0, the address field is the operand address. Code 0 ANDs the word there into AC, code 1 adds it, code 2 loads it and code 3 stores AC there.
- R4: ADD sets E to the carry out of the 16-bit sum. AND and LDA leave E unchanged.
- R5: With the mode bit at 1 and a code from 0 to 6, the low 12 bits of the word at the address field are used as the operand address.
- R6: Code 4 sets the PC to the operand address. Code 5 writes the PC into the word at the operand address and then sets the PC to that address plus one.
- R7: Code 6 adds one to the word at the operand address and writes it back. When the new value is zero, the PC is incremented once more.
- R8: Code 7 with mode 0 is a register operation, with these bits: 11 clears AC, 10 clears E, 9 inverts AC, 8 inverts E, 7 rotates {AC,E} right (E enters AC bit 15 and AC bit 0 enters E), 6 rotates left (E enters AC bit 0 and AC bit 15 enters E), and 5 increments AC.
- R9: In a register operation, bits 4, 3, 2 and 1 skip the next word when AC is positive (bit 15 clear), AC is negative, AC is zero, or E is zero, respectively. The tests use the values held before the word executes.
- R10: Code 7 with mode 1 (I/O class) leaves AC, E and the store unchanged and goes on to the next word.
- R11: A register operation with bit 0 set stops the machine. `halted` then stays high, and PC, AC and IR hold until reset.
- R12: A pulse on `pre_we` writes `pre_data` to the word at `pre_addr`, and the running program sees that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer (the store is not cleared) |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word value |
| halted | output | 1 | High once a halt operation has executed |
| pc_view | output | 12 | Program counter |
| ac_view | output | 16 | Accumulator |
| ir_view | output | 16 | Instruction register |

## Verification
The assertions assume the preload port is used only while reset is held. A write from outside during a run could change a word between the fetch and the execute steps that read it. The bench loads every program with reset low and releases reset only after the last preload write. Each program also ends with a reachable halt word, so the hold checks for the stopped state are always reached. Programs are placed so that no fetch runs into an unloaded address.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH_A = 3'd0,
        PH_FETCH_W = 3'd1,
        PH_DECODE  = 3'd2,
        PH_POINTER = 3'd3,
        PH_EXEC0   = 3'd4,
        PH_EXEC1   = 3'd5,
        PH_EXEC2   = 3'd6,
        PH_STOPPED = 3'd7
    } phase_e;

    localparam logic [2:0] OP_AND = 3'd0;
    localparam logic [2:0] OP_ADD = 3'd1;
    localparam logic [2:0] OP_LDA = 3'd2;
    localparam logic [2:0] OP_STA = 3'd3;
    localparam logic [2:0] OP_BUN = 3'd4;
    localparam logic [2:0] OP_BSA = 3'd5;
    localparam logic [2:0] OP_ISZ = 3'd6;
    localparam logic [2:0] OP_EXT = 3'd7;

endpackage

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    // Preload port wins over the sequencer on a shared cycle.
    always_ff @(posedge clk) begin
        if (pre_we) begin
            words_q[pre_addr] <= pre_data;
        end else if (cpu_we) begin
            words_q[cpu_addr] <= cpu_wdata;
        end
    end

    assign cpu_rdata = words_q[cpu_addr];

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              e_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              e_out
);
    import acc_seq_pkg::*;

    logic [DATA_W:0] sum;

    always_comb begin
        sum     = {1'b0, acc} + {1'b0, opnd};
        acc_out = acc;
        e_out   = e_in;
        case (op)
            OP_AND: acc_out = acc & opnd;
            OP_ADD: begin
                acc_out = sum[DATA_W-1:0];
                e_out   = sum[DATA_W];
            end
            OP_LDA: acc_out = opnd;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_seq_regunit.sv
module acc_seq_regunit #(
    parameter int DATA_W = 16,
    parameter int CTL_W  = 12
) (
    input  logic [CTL_W-1:0]  ctl,
    input  logic [DATA_W-1:0] acc,
    input  logic              e_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              e_out,
    output logic              skip,
    output logic              stop
);
    logic [DATA_W-1:0] a;
    logic              e;
    logic              tmp;

    always_comb begin
        a = acc;
        e = e_in;
        if (ctl[11]) a = '0;
        if (ctl[10]) e = 1'b0;
        if (ctl[9])  a = ~a;
        if (ctl[8])  e = ~e;
        if (ctl[7]) begin
            tmp = a[0];
            a   = {e, a[DATA_W-1:1]};
            e   = tmp;
        end
        if (ctl[6]) begin
            tmp = a[DATA_W-1];
            a   = {a[DATA_W-2:0], e};
            e   = tmp;
        end
        if (ctl[5]) a = a + DATA_W'(1);
        tmp     = 1'b0;
        acc_out = a;
        e_out   = e;
        skip    = (ctl[4] && !acc[DATA_W-1])
               || (ctl[3] &&  acc[DATA_W-1])
               || (ctl[2] && (acc == '0))
               || (ctl[1] && !e_in);
        stop    = ctl[0];
    end

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_view,
    output logic [DATA_W-1:0] ac_view,
    output logic [DATA_W-1:0] ir_view
);
    import acc_seq_pkg::*;

    localparam int MODE_BIT = DATA_W - 1;
    localparam int OP_LO    = DATA_W - 4;
    localparam int PAD_W    = DATA_W - ADDR_W;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ac;
        logic              e;
    } seq_state_t;

    seq_state_t s_q, s_d;

    logic              mem_we_d;
    logic [DATA_W-1:0] mem_wdata_d;
    logic [DATA_W-1:0] mem_rdata;

    logic              ind_q;
    logic [2:0]        op_q;
    logic [DATA_W-1:0] alu_ac;
    logic              alu_e;
    logic [DATA_W-1:0] ru_ac;
    logic              ru_e;
    logic              ru_skip;
    logic              ru_stop;

    assign ind_q = s_q.ir[MODE_BIT];
    assign op_q  = s_q.ir[MODE_BIT-1:OP_LO];

    acc_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .cpu_we   (mem_we_d),
        .cpu_addr (s_q.ar),
        .cpu_wdata(mem_wdata_d),
        .cpu_rdata(mem_rdata)
    );

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (op_q),
        .acc    (s_q.ac),
        .opnd   (s_q.dr),
        .e_in   (s_q.e),
        .acc_out(alu_ac),
        .e_out  (alu_e)
    );

    acc_seq_regunit #(.DATA_W(DATA_W), .CTL_W(ADDR_W)) u_reg (
        .ctl    (s_q.ir[ADDR_W-1:0]),
        .acc    (s_q.ac),
        .e_in   (s_q.e),
        .acc_out(ru_ac),
        .e_out  (ru_e),
        .skip   (ru_skip),
        .stop   (ru_stop)
    );

    always_comb begin
        s_d         = s_q;
        mem_we_d    = 1'b0;
        mem_wdata_d = s_q.ac;
        case (s_q.phase)
            PH_FETCH_A: begin
                s_d.ar    = s_q.pc;
                s_d.phase = PH_FETCH_W;
            end
            PH_FETCH_W: begin
                s_d.ir    = mem_rdata;
                s_d.pc    = s_q.pc + ADDR_W'(1);
                s_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                s_d.ar = s_q.ir[ADDR_W-1:0];
                if (op_q != OP_EXT && ind_q) begin
                    s_d.phase = PH_POINTER;
                end else begin
                    s_d.phase = PH_EXEC0;
                end
            end
            PH_POINTER: begin
                s_d.ar    = mem_rdata[ADDR_W-1:0];
                s_d.phase = PH_EXEC0;
            end
            PH_EXEC0: begin
                s_d.phase = PH_FETCH_A;
                case (op_q)
                    OP_AND, OP_ADD, OP_LDA, OP_ISZ: begin
                        s_d.dr    = mem_rdata;
                        s_d.phase = PH_EXEC1;
                    end
                    OP_STA: mem_we_d = 1'b1;
                    OP_BUN: s_d.pc = s_q.ar;
                    OP_BSA: begin
                        mem_we_d    = 1'b1;
                        mem_wdata_d = {{PAD_W{1'b0}}, s_q.pc};
                        s_d.ar      = s_q.ar + ADDR_W'(1);
                        s_d.phase   = PH_EXEC1;
                    end
                    default: begin
                        if (!ind_q) begin
                            s_d.ac = ru_ac;
                            s_d.e  = ru_e;
                            if (ru_skip) s_d.pc = s_q.pc + ADDR_W'(1);
                            if (ru_stop) s_d.phase = PH_STOPPED;
                        end
                    end
                endcase
            end
            PH_EXEC1: begin
                s_d.phase = PH_FETCH_A;
                case (op_q)
                    OP_BSA: s_d.pc = s_q.ar;
                    OP_ISZ: begin
                        s_d.dr    = s_q.dr + DATA_W'(1);
                        s_d.phase = PH_EXEC2;
                    end
                    default: begin
                        s_d.ac = alu_ac;
                        s_d.e  = alu_e;
                    end
                endcase
            end
            PH_EXEC2: begin
                mem_we_d    = 1'b1;
                mem_wdata_d = s_q.dr;
                if (s_q.dr == '0) s_d.pc = s_q.pc + ADDR_W'(1);
                s_d.phase   = PH_FETCH_A;
            end
            default: s_d.phase = PH_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FETCH_A, pc: '0, ar: '0, ir: '0,
                     dr: '0, ac: '0, e: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign halted  = (s_q.phase == PH_STOPPED);
    assign pc_view = s_q.pc;
    assign ac_view = s_q.ac;
    assign ir_view = s_q.ir;

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FETCH_W) |=> (s_q.pc == $past(s_q.pc) + ADDR_W'(1)));

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_FETCH_W) |=> $stable(s_q.ir));

    assert_ar_from_ir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_DECODE) |=> (s_q.ar == $past(s_q.ir[ADDR_W-1:0])));

    assert_no_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_EXEC0 && op_q == OP_EXT && !ind_q && s_q.ir[4:1] == 4'd0)
        |=> (s_q.pc == $past(s_q.pc)));

    assert_io_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_EXEC0 && op_q == OP_EXT && ind_q)
        |=> ($stable(s_q.ac) && $stable(s_q.e) && !$past(mem_we_d)));

    assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(s_q.pc) && $stable(s_q.ac) && $stable(s_q.ir)));

endmodule

// File: tb/acc_seq_top_tb.sv
module acc_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TIMEOUT    = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_we = 1'b0;
    logic [11:0] pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic        halted;
    logic [11:0] pc_view;
    logic [15:0] ac_view;
    logic [15:0] ir_view;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [15:0] ac;
        logic [11:0] pc;
        logic [15:0] ir;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    bit   got = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .halted(halted), .pc_view(pc_view),
        .ac_view(ac_view), .ir_view(ir_view)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_addr = a;
        pre_data = d;
        @(negedge clk);
        pre_we   = 1'b0;
    endtask

    task automatic start_and_wait(input exp_t e);
        int n;
        exp_q.push_back(e);
        got = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!got && n < TIMEOUT) begin
            @(negedge clk);
            n++;
        end
        if (!got) begin
            checks++;
            failures++;
            $display("FAIL %s watchdog actual=running expected=halted", e.tag);
            void'(exp_q.pop_front());
        end
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compares the state shown at the ports once the machine stops.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && halted && !got) begin
                exp_t e;
                got = 1'b1;
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check(ac_view, e.ac, {e.tag, " ac"});
                    check({4'h0, pc_view}, {4'h0, e.pc}, {e.tag, " pc"});
                    check(ir_view, e.ir, {e.tag, " ir"});
                end
            end
        end
    end

    initial begin
        logic [11:0] pc_hold;
        logic [15:0] ac_hold;
        // R1: reset state
        repeat (3) @(negedge clk);
        check({4'h0, pc_view}, 16'h0, "R1 pc");
        check(ac_view, 16'h0, "R1 ac");
        check(ir_view, 16'h0, "R1 ir");
        check({15'h0, halted}, 16'h0, "R1 halted");

        // R3 R12: direct load, add, store, and
        put(12'h000, 16'h2010); put(12'h001, 16'h1011); put(12'h002, 16'h3012);
        put(12'h003, 16'h7800); put(12'h004, 16'h2012); put(12'h005, 16'h0013);
        put(12'h006, 16'h7001);
        put(12'h010, 16'h1234); put(12'h011, 16'h0F0F); put(12'h013, 16'h00FF);
        start_and_wait('{ac: 16'h0043, pc: 12'h007, ir: 16'h7001, tag: "R3 R12 R2 direct"});

        // R11: stopped state holds
        put(12'h000, 16'h7020); put(12'h001, 16'h7001);
        exp_q.push_back('{ac: 16'h0001, pc: 12'h002, ir: 16'h7001, tag: "R11 stop"});
        got = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (40) @(negedge clk);
        pc_hold = pc_view; ac_hold = ac_view;
        repeat (6) @(negedge clk);
        check({4'h0, pc_view}, {4'h0, pc_hold}, "R11 pc held");
        check(ac_view, ac_hold, "R11 ac held");
        check({15'h0, halted}, 16'h1, "R11 halted");
        rst_n = 1'b0;
        @(negedge clk);
        check({15'h0, halted}, 16'h0, "R1 halted after reset");

        // R5 R4: indirect operands and carry into E
        put(12'h000, 16'hA020); put(12'h001, 16'h9021); put(12'h002, 16'h7040);
        put(12'h003, 16'h7001);
        put(12'h020, 16'h0030); put(12'h021, 16'h0031);
        put(12'h030, 16'hFFFF); put(12'h031, 16'h0002);
        start_and_wait('{ac: 16'h0003, pc: 12'h004, ir: 16'h7001, tag: "R5 R4 indirect carry"});

        // R6 R7: branch, subroutine link, increment-and-skip
        put(12'h000, 16'h2040); put(12'h001, 16'h5050); put(12'h002, 16'h6041);
        put(12'h003, 16'h7001); put(12'h004, 16'h6041); put(12'h005, 16'h2041);
        put(12'h006, 16'h1050); put(12'h007, 16'h7001);
        put(12'h040, 16'h0005); put(12'h041, 16'hFFFF); put(12'h050, 16'h0000);
        put(12'h051, 16'h7020); put(12'h052, 16'hC050);
        start_and_wait('{ac: 16'h0003, pc: 12'h008, ir: 16'h7001, tag: "R6 R7 branch"});

        // R8 R9 R10: register ops, skips, I/O class
        put(12'h000, 16'h7800); put(12'h001, 16'h7200); put(12'h002, 16'h7008);
        put(12'h003, 16'h7001); put(12'h004, 16'h7020); put(12'h005, 16'h7004);
        put(12'h006, 16'h7001); put(12'h007, 16'h7100); put(12'h008, 16'h7080);
        put(12'h009, 16'h7002); put(12'h00A, 16'h7001); put(12'h00B, 16'hF800);
        put(12'h00C, 16'h7010); put(12'h00D, 16'h7001);
        start_and_wait('{ac: 16'h8000, pc: 12'h00E, ir: 16'h7001, tag: "R8 R9 R10 regops"});

        // R4: AND keeps E from ADD
        put(12'h000, 16'h2060); put(12'h001, 16'h1060); put(12'h002, 16'h0061);
        put(12'h003, 16'h7040); put(12'h004, 16'h7001);
        put(12'h060, 16'hFFFF); put(12'h061, 16'h00F0);
        start_and_wait('{ac: 16'h01E1, pc: 12'h005, ir: 16'h7001, tag: "R4 and keeps E"});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule